// File: doc/BRIEF.md
# Chained Interrupt Acknowledge with Vector Return

This block groups a set of interrupt-capable device slots behind one request line to the processor. A slot latches a request only while it holds the bus-master grant; every latched request contributes to a single shared request output. When the processor answers with an acknowledge, the acknowledge enters the chain at slot 0 and moves slot by slot. The first slot that holds a pending request keeps the acknowledge and does not pass it on. That slot's programmable vector is returned to the processor on an 8-bit vector bus, together with a one-cycle valid strobe. The processor uses the vector to choose a handler.

Each slot's vector is an input, so the surrounding logic can reprogram it at any time. The answering slot's pending request is cleared when its vector is delivered. If the acknowledge passes through every slot without being taken, the block returns a spurious vector of all ones, so the processor always receives an answer.

Top module: `vec_irq_chain`

## Requirements
- R1: A slot's pending request is set at a clock edge only when its `raise_req` bit and its `bus_grant` bit are both 1 at that edge. A `raise_req` bit without its grant has no effect.
- R2: `irq_out` is 1 exactly when at least one slot has a pending request. It follows the pending state registered at the previous edge.
- R3: Each clock edge with `ack` high produces `vec_valid` high during the next cycle. `vec_valid` is low in the cycle after an edge with `ack` low.
- R4: The acknowledge is taken by the lowest-numbered slot that has a pending request. Slot 0 has the highest priority.
- R5: When a slot takes the acknowledge, `vec_out` in the next cycle equals that slot's vector. Slot i's vector is the field `slot_vec[8*i+7 : 8*i]`, sampled at the acknowledge edge.
- R6: The pending request of the answering slot is cleared at the acknowledge edge. The other slots keep their pending requests.
- R7: If no slot is pending at an acknowledge edge, `vec_out` is 8'hFF in the next cycle, with `vec_valid` high.
- R8: If a granted `raise_req` for the answering slot arrives at the same edge as the acknowledge, that slot delivers its vector and stays pending.
- R9: While `rst_n` is low, all pending requests are cleared and `irq_out`, `vec_valid` and `vec_out` are 0.
- R10: `vec_out` is 0 in every cycle where `vec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| raise_req | input | NSLOT | Per-slot request raise, one bit per slot |
| bus_grant | input | NSLOT | Per-slot bus-master grant; a raise counts only while granted |
| slot_vec | input | NSLOT*VEC_W | Per-slot vectors; slot i uses bits [VEC_W*i +: VEC_W] |
| ack | input | 1 | Interrupt acknowledge from the processor |
| irq_out | output | 1 | Shared interrupt request line |
| vec_out | output | VEC_W | Returned vector, 0 when not valid |
| vec_valid | output | 1 | Vector qualifier, high for one cycle per acknowledge cycle |

## Verification
A granted raise first appears on `irq_out` one cycle after its edge. An acknowledge sampled at an edge produces `vec_valid` and `vec_out` in the following cycle, and its clear of the answering slot is visible on `irq_out` in that same cycle. The bench drives inputs and compares all three outputs at the falling edge. Its behavioural model updates at the rising edge from the same inputs the design sees, so each expected value is due in exactly the cycle where the registered output changes. Directed sequences cover priority ties, ungranted raises, empty acknowledges and a raise that coincides with an acknowledge; a long random run follows.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int VEC_W = 8;

  typedef logic [VEC_W-1:0] vec_t;

  // Answer returned when the acknowledge finds no pending slot.
  function automatic vec_t spurious_vec();
    return '1;
  endfunction

  // Next pending state for one slot: taken -> cleared, granted raise -> set.
  function automatic logic next_pending(input logic cur, input logic taken,
                                        input logic raise, input logic grant);
    return (cur & ~taken) | (raise & grant);
  endfunction
endpackage

// File: rtl/irqc_slot.sv
module irqc_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic grant,
  input  logic ack_in,
  output logic ack_out,
  output logic taken,
  output logic pending
);
  import irqc_pkg::*;

  logic pend_q;

  // A pending slot absorbs the acknowledge; an idle slot passes it on.
  assign taken   = ack_in & pend_q;
  assign ack_out = ack_in & ~pend_q;
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= next_pending(pend_q, taken, raise, grant);
  end
endmodule

// File: rtl/irqc_vec_sel.sv
module irqc_vec_sel #(
  parameter int NSLOT = 4,
  parameter int VEC_W = 8
) (
  input  logic [NSLOT-1:0]       taken,
  input  logic                   fell_through,
  input  logic [NSLOT*VEC_W-1:0] slot_vec,
  output logic [VEC_W-1:0]       vec_sel
);
  logic [VEC_W-1:0] part [NSLOT+1];

  assign part[0] = fell_through ? {VEC_W{1'b1}} : '0;

  // At most one slot is taken, so an OR of masked vectors selects it.
  for (genvar i = 0; i < NSLOT; i++) begin : g_or
    assign part[i+1] = part[i] | (slot_vec[VEC_W*i +: VEC_W] & {VEC_W{taken[i]}});
  end

  assign vec_sel = part[NSLOT];
endmodule

// File: rtl/vec_irq_chain.sv
module vec_irq_chain #(
  parameter int NSLOT = 4,
  parameter int VEC_W = irqc_pkg::VEC_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       raise_req,
  input  logic [NSLOT-1:0]       bus_grant,
  input  logic [NSLOT*VEC_W-1:0] slot_vec,
  input  logic                   ack,
  output logic                   irq_out,
  output logic [VEC_W-1:0]       vec_out,
  output logic                   vec_valid
);
  // Named internal events for the checker.
  logic [NSLOT:0]   ack_chain;
  logic [NSLOT-1:0] taken;
  logic [NSLOT-1:0] pend;
  logic             fell_through;
  logic [VEC_W-1:0] vec_sel;

  assign ack_chain[0] = ack;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    irqc_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .raise   (raise_req[i]),
      .grant   (bus_grant[i]),
      .ack_in  (ack_chain[i]),
      .ack_out (ack_chain[i+1]),
      .taken   (taken[i]),
      .pending (pend[i])
    );
  end

  assign fell_through = ack_chain[NSLOT];
  assign irq_out      = |pend;

  irqc_vec_sel #(.NSLOT(NSLOT), .VEC_W(VEC_W)) u_sel (
    .taken        (taken),
    .fell_through (fell_through),
    .slot_vec     (slot_vec),
    .vec_sel      (vec_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      vec_valid <= ack;
      vec_out   <= ack ? vec_sel : '0;
    end
  end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int NSLOT = 4,
  parameter int VEC_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSLOT-1:0]       raise_req,
  input logic [NSLOT-1:0]       bus_grant,
  input logic                   ack,
  input logic [NSLOT-1:0]       taken,
  input logic [NSLOT-1:0]       pend,
  input logic                   irq_out,
  input logic [VEC_W-1:0]       vec_out,
  input logic                   vec_valid
);
  assert_one_taker_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(taken));

  assert_strobe_follows_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> vec_valid);

  assert_no_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> !vec_valid);

  assert_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_out) |=> (vec_out == {VEC_W{1'b1}}));

  assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_out == '0));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot_chk
    assert_raise_needs_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend[i] && !(raise_req[i] && bus_grant[i])) |=> !pend[i]);

    assert_taken_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (taken[i] && !(raise_req[i] && bus_grant[i])) |=> !pend[i]);

    assert_untaken_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !taken[i]) |=> pend[i]);
  end
endmodule

bind vec_irq_chain irqc_checker #(.NSLOT(NSLOT), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .raise_req (raise_req),
  .bus_grant (bus_grant),
  .ack       (ack),
  .taken     (taken),
  .pend      (pend),
  .irq_out   (irq_out),
  .vec_out   (vec_out),
  .vec_valid (vec_valid)
);

// File: tb/vec_irq_chain_bench.sv
`timescale 1ns/1ps
module vec_irq_chain_bench;
  localparam int NS = 4;
  localparam int VW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NS-1:0]   raise_req = '0;
  logic [NS-1:0]   bus_grant = '0;
  logic [NS*VW-1:0] slot_vec = '0;
  logic            ack = 1'b0;
  logic            irq_out;
  logic [VW-1:0]   vec_out;
  logic            vec_valid;

  int n_chk = 0;
  int n_bad = 0;

  // Behavioural reference state.
  bit        m_pend [NS];
  bit        m_valid;
  int        m_vec;

  always #2.5 clk = ~clk;

  vec_irq_chain #(.NSLOT(NS), .VEC_W(VW)) u_vec_irq_chain (
    .clk(clk), .rst_n(rst_n), .raise_req(raise_req), .bus_grant(bus_grant),
    .slot_vec(slot_vec), .ack(ack), .irq_out(irq_out), .vec_out(vec_out),
    .vec_valid(vec_valid)
  );

  function automatic int field(input int s);
    return int'((slot_vec >> (VW * s)) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_pend[k]) m_pend[k] = 0;
      m_valid = 0;
      m_vec   = 0;
    end else begin
      int winner;
      winner  = -1;
      m_valid = ack;
      m_vec   = 0;
      if (ack) begin
        for (int k = NS - 1; k >= 0; k--) if (m_pend[k]) winner = k;
        m_vec = (winner < 0) ? 255 : field(winner);
        if (winner >= 0) m_pend[winner] = 0;
      end
      for (int k = 0; k < NS; k++)
        if (raise_req[k] && bus_grant[k]) m_pend[k] = 1;
    end
  end

  function automatic bit m_any();
    bit r;
    r = 0;
    foreach (m_pend[k]) r |= m_pend[k];
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare all outputs against the model; tag names the requirement under test.
  task automatic compare(input string ctx);
    check({ctx, " R2 irq_out"}, int'(irq_out), int'(m_any()));
    check({ctx, " R3 vec_valid"}, int'(vec_valid), int'(m_valid));
    if (!m_valid)          check({ctx, " R10 vec_out"}, int'(vec_out), m_vec);
    else if (m_vec == 255) check({ctx, " R7 vec_out"}, int'(vec_out), m_vec);
    else                   check({ctx, " R5 vec_out"}, int'(vec_out), m_vec);
  endtask

  // Advance one cycle: apply inputs after a falling edge, compare at the next one.
  task automatic step(input logic [NS-1:0] r, input logic [NS-1:0] g,
                      input logic a, input string ctx);
    raise_req = r;
    bus_grant = g;
    ack       = a;
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    slot_vec = {8'h43, 8'h32, 8'h21, 8'h10};
    repeat (3) @(negedge clk);
    // R9: reset state.
    check("R9 irq_out reset", int'(irq_out), 0);
    check("R9 vec_valid reset", int'(vec_valid), 0);
    check("R9 vec_out reset", int'(vec_out), 0);
    rst_n = 1'b1;

    step(4'b0100, 4'b0100, 1'b0, "R1 granted raise");
    step(4'b0000, 4'b0000, 1'b1, "R5 ack slot2");
    check("R6 slot2 cleared", int'(irq_out), 0);
    step(4'b0000, 4'b0000, 1'b0, "idle");

    step(4'b0010, 4'b0000, 1'b0, "R1 ungranted raise");
    check("R1 ungranted ignored", int'(irq_out), 0);
    step(4'b0000, 4'b0000, 1'b1, "R7 empty ack");
    check("R7 spurious", int'(vec_out), 255);

    step(4'b1010, 4'b1111, 1'b0, "R4 two raises");
    step(4'b0000, 4'b0000, 1'b1, "R4 first ack");
    check("R4 slot1 wins", int'(vec_out), 8'h21);
    check("R6 slot3 still pending", int'(irq_out), 1);
    step(4'b0000, 4'b0000, 1'b1, "R4 second ack");
    check("R4 slot3 next", int'(vec_out), 8'h43);
    step(4'b0000, 4'b0000, 1'b1, "R3 held ack");
    check("R7 held ack empty", int'(vec_out), 255);

    step(4'b0001, 4'b0001, 1'b0, "R8 setup");
    step(4'b0001, 4'b0001, 1'b1, "R8 raise with ack");
    check("R8 slot0 delivered", int'(vec_out), 8'h10);
    check("R8 slot0 still pending", int'(irq_out), 1);
    step(4'b0000, 4'b0000, 1'b1, "R8 drain");
    step(4'b0000, 4'b0000, 1'b0, "idle");
    check("R10 quiet bus", int'(vec_out), 0);

    for (int c = 0; c < 400; c++) begin
      if (c % 50 == 0) slot_vec = {$urandom, $urandom};
      step(4'($urandom), 4'($urandom), 1'($urandom % 3 == 0), "random");
    end

    rst_n = 1'b0;
    step(4'b1111, 4'b1111, 1'b1, "R9 reset again");
    check("R9 irq after reset", int'(irq_out), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule